// File: doc/BRIEF.md
# ECC Fault Status and Injection Register Block

This block collects fault reports from an ECC decoder that sits on a memory read path. Each read comes with a one-cycle valid strobe and two decoder indications, one for a correctable single-bit fault and one for an uncorrectable double-bit fault, plus the address and data of that read. The block keeps a sticky flag for each fault class. For the first genuine fault it also keeps a capture of the read's address and data, and it holds that capture until firmware has dealt with it.

Firmware can set two force bits. While a force bit is set, every qualified read raises the matching flag, so interrupt handlers can be exercised without a defective memory. A forced fault never loads the capture registers; only a real decoder report does. A byte-wide interrupt-enable register gates the flags onto one registered interrupt output. All registers sit behind a simple byte-wide write port and a read port with one cycle of latency.

Register map (byte offsets): 0x0 control, where bit 1 forces double faults and bit 0 forces single faults. 0x1 interrupt enables. 0x2 status, where bit 1 is the double-fault flag and bit 0 is the single-fault flag; writing 1 to a bit clears it. From 0x4 upward come the capture bytes: the address bytes first, least significant byte first, then the data bytes, least significant byte first. Unused bits and unused offsets read 0.

Top module: `ecc_err_flags`

## Requirements
- R1: While control bit 1 (double force) is set, every read with `rd_vld` high sets status bit 1, whatever the decoder reports.
- R2: While control bit 0 (single force) is set, every read with `rd_vld` high sets status bit 0, whatever the decoder reports.
- R3: A read whose fault is only forced, with both decoder indications low, leaves the capture address and data bytes unchanged.
- R4: With the matching force bit clear, a status flag is set only by a qualified read on which the decoder reports that fault class.
- R5: A force bit stays set across any number of reads until software writes 0 to it.
- R6: `irq` is 1 exactly when (status bit 1 and enable bit 1) or (status bit 0 and enable bit 0). It changes in the same cycle as the flags and enables it depends on.
- R7: The enable register at 0x1 resets to 0x00. It keeps bits 7, 6, 4, 3, 2, 1 and 0 as written. Bit 5 is reserved: it always reads 0 and ignores writes.
- R8: Status flags are sticky and are cleared by writing 1 to their bit at 0x2. Writing 0 leaves a flag unchanged. When a set and a clear fall in the same cycle, the flag ends up set.
- R9: While `rd_vld` is low, neither the force bits nor the decoder indications change any flag.
- R10: When both decoder indications are high on one read, only status bit 1 is set (unless single force is on), and the capture records that read.
- R11: Once a real fault loads the capture, later real faults do not overwrite it until the flag of the captured fault class has been cleared.
- R12: After reset all registers read 0 and `irq` is 0. Read data appears on `bus_rdata` one clock after `bus_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_vld | input | 1 | One-cycle strobe qualifying a memory read |
| rd_sgl | input | 1 | Decoder reports a single-bit fault on this read |
| rd_dbl | input | 1 | Decoder reports a double-bit fault on this read |
| rd_addr | input | ADDR_W | Address of the current read |
| rd_data | input | DATA_W | Data of the current read |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's offset |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The bound checker checks on every cycle that forced reads set their flags, that forced-only reads leave the capture untouched, that flags do not rise without a qualified read, that a locked capture stays stable, that the reserved enable bit stays zero and that the interrupt matches the flags and enables. Only the bench's scenarios can show the register map and read latency, the priority of a double over a single report on the same read, the set-beats-clear outcome seen through the bus, a force bit persisting over repeated reads, and the capture reloading only after its flag has been cleared.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] OFS_CTRL = 4'h0;
  localparam logic [REG_AW-1:0] OFS_IEN  = 4'h1;
  localparam logic [REG_AW-1:0] OFS_STAT = 4'h2;
  localparam logic [REG_AW-1:0] OFS_CAP  = 4'h4;
  localparam int FLAG_SGL = 0;
  localparam int FLAG_DBL = 1;
  localparam int IEN_RSV  = 5;
  localparam logic [7:0] IEN_MASK = 8'hDF;
  typedef enum logic { KIND_SGL = 1'b0, KIND_DBL = 1'b1 } fault_kind_e;
endpackage

// File: rtl/ecc_fault_detect.sv
module ecc_fault_detect
  import ecc_err_pkg::*;
(
  input  logic        rd_vld,
  input  logic        rd_sgl,
  input  logic        rd_dbl,
  input  logic [1:0]  force_bits,
  output logic [1:0]  flag_set,
  output logic        cap_req,
  output fault_kind_e cap_kind
);
  always_comb begin
    flag_set[FLAG_DBL] = rd_vld & (rd_dbl | force_bits[FLAG_DBL]);
    flag_set[FLAG_SGL] = rd_vld & ((rd_sgl & ~rd_dbl) | force_bits[FLAG_SGL]);
    cap_req            = rd_vld & (rd_sgl | rd_dbl);
    cap_kind           = rd_dbl ? KIND_DBL : KIND_SGL;
  end
endmodule

// File: rtl/ecc_flag_bits.sv
module ecc_flag_bits #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_in,
  input  logic [N-1:0] clr_in,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] flag_d
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    assign flag_d[i] = set_in[i] | (flag_q[i] & ~clr_in[i]);
    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/ecc_capture.sv
module ecc_capture
  import ecc_err_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_req,
  input  fault_kind_e       cap_kind,
  input  logic [1:0]        flag_next,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_lock
);
  fault_kind_e held_kind;
  logic        load;

  assign load = cap_req & ~cap_lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_addr  <= '0;
      cap_data  <= '0;
      cap_lock  <= 1'b0;
      held_kind <= KIND_SGL;
    end else if (load) begin
      cap_addr  <= rd_addr;
      cap_data  <= rd_data;
      cap_lock  <= 1'b1;
      held_kind <= cap_kind;
    end else if (cap_lock && !flag_next[held_kind]) begin
      cap_lock  <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_err_flags.sv
module ecc_err_flags
  import ecc_err_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_vld,
  input  logic              rd_sgl,
  input  logic              rd_dbl,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [3:0]        bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam int AB        = (ADDR_W + 7) / 8;
  localparam int DB        = (DATA_W + 7) / 8;
  localparam int CAP_BYTES = AB + DB;

  logic [1:0]        force_q;
  logic [7:0]        ien_q, ien_nxt;
  logic [1:0]        flag_set, flag_clr, flag_q, flag_d;
  logic              cap_req, cap_lock;
  fault_kind_e       cap_kind;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic [AB*8-1:0]   addr_pad;
  logic [DB*8-1:0]   data_pad;
  logic [CAP_BYTES*8-1:0] cap_vec;
  logic [7:0]        rd_mux;
  logic              wr_ctrl, wr_ien, wr_stat;

  assign wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
  assign wr_ien   = bus_we && (bus_addr == OFS_IEN);
  assign wr_stat  = bus_we && (bus_addr == OFS_STAT);
  assign flag_clr = wr_stat ? bus_wdata[1:0] : 2'b00;
  assign ien_nxt  = wr_ien ? (bus_wdata & IEN_MASK) : ien_q;

  ecc_fault_detect u_detect (
    .rd_vld    (rd_vld),
    .rd_sgl    (rd_sgl),
    .rd_dbl    (rd_dbl),
    .force_bits(force_q),
    .flag_set  (flag_set),
    .cap_req   (cap_req),
    .cap_kind  (cap_kind)
  );

  ecc_flag_bits #(.N(2)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set_in(flag_set),
    .clr_in(flag_clr),
    .flag_q(flag_q),
    .flag_d(flag_d)
  );

  ecc_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .cap_req  (cap_req),
    .cap_kind (cap_kind),
    .flag_next(flag_d),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .cap_addr (cap_addr),
    .cap_data (cap_data),
    .cap_lock (cap_lock)
  );

  always_comb begin
    addr_pad               = '0;
    addr_pad[ADDR_W-1:0]   = cap_addr;
    data_pad               = '0;
    data_pad[DATA_W-1:0]   = cap_data;
    cap_vec                = {data_pad, addr_pad};
  end

  always_comb begin
    rd_mux = 8'h00;
    case (bus_addr)
      OFS_CTRL: rd_mux = {6'b0, force_q};
      OFS_IEN:  rd_mux = ien_q;
      OFS_STAT: rd_mux = {6'b0, flag_q};
      default: begin
        for (int b = 0; b < CAP_BYTES; b++) begin
          if (int'(bus_addr) == int'(OFS_CAP) + b) rd_mux = cap_vec[b*8 +: 8];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      force_q   <= 2'b00;
      ien_q     <= 8'h00;
      bus_rdata <= 8'h00;
      irq       <= 1'b0;
    end else begin
      if (wr_ctrl) force_q <= bus_wdata[1:0];
      ien_q     <= ien_nxt;
      bus_rdata <= rd_mux;
      irq       <= |(flag_d & ien_nxt[1:0]);
    end
  end
endmodule

// File: rtl/ecc_err_flags_chk.sv
module ecc_err_flags_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_vld,
  input logic              rd_sgl,
  input logic              rd_dbl,
  input logic [1:0]        force_q,
  input logic [1:0]        flag_q,
  input logic [7:0]        ien_q,
  input logic              cap_lock,
  input logic [ADDR_W-1:0] cap_addr,
  input logic [DATA_W-1:0] cap_data,
  input logic              irq
);
  p_force_dbl_r1: assert property (@(posedge clk) disable iff (rst)
    rd_vld && force_q[1] |=> flag_q[1]);

  p_force_sgl_r2: assert property (@(posedge clk) disable iff (rst)
    rd_vld && force_q[0] |=> flag_q[0]);

  p_forced_nocap_r3: assert property (@(posedge clk) disable iff (rst)
    !(rd_vld && (rd_sgl || rd_dbl)) |=> $stable(cap_addr) && $stable(cap_data));

  p_real_only_r4: assert property (@(posedge clk) disable iff (rst)
    !flag_q[0] && !force_q[0] && !(rd_vld && rd_sgl && !rd_dbl) |=> !flag_q[0]);

  p_irq_r6: assert property (@(posedge clk) disable iff (rst)
    irq == ((flag_q[1] && ien_q[1]) || (flag_q[0] && ien_q[0])));

  p_rsv_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !ien_q[5]);

  p_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_vld && !flag_q[1] |=> !flag_q[1]);

  p_cap_hold_r11: assert property (@(posedge clk) disable iff (rst)
    cap_lock |=> $stable(cap_addr) && $stable(cap_data));
endmodule

bind ecc_err_flags ecc_err_flags_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_vld  (rd_vld),
  .rd_sgl  (rd_sgl),
  .rd_dbl  (rd_dbl),
  .force_q (force_q),
  .flag_q  (flag_q),
  .ien_q   (ien_q),
  .cap_lock(cap_lock),
  .cap_addr(cap_addr),
  .cap_data(cap_data),
  .irq     (irq)
);

// File: tb/ecc_err_flags_test.sv
module ecc_err_flags_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_vld = 1'b0, rd_sgl = 1'b0, rd_dbl = 1'b0;
  logic [15:0] rd_addr = '0, rd_data = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq;
  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  ecc_err_flags #(.ADDR_W(16), .DATA_W(16)) uut (
    .clk(clk), .rst(rst), .rd_vld(rd_vld), .rd_sgl(rd_sgl), .rd_dbl(rd_dbl),
    .rd_addr(rd_addr), .rd_data(rd_data), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 4'd1, hi);
    d = {hi, lo};
  endtask

  task automatic mem_read(input logic s, input logic db, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    rd_vld = 1'b1; rd_sgl = s; rd_dbl = db; rd_addr = a; rd_data = d;
    @(negedge clk);
    rd_vld = 1'b0; rd_sgl = 1'b0; rd_dbl = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    logic [15:0] w;
    rd(4'h0, v); chk("R12 ctrl reset", 16'(v), 16'h0);
    rd(4'h1, v); chk("R12 ien reset", 16'(v), 16'h0);
    rd(4'h2, v); chk("R12 stat reset", 16'(v), 16'h0);
    rd16(4'h4, w); chk("R12 cap addr reset", w, 16'h0);
    chk("R12 irq reset", 16'(irq), 16'h0);
  endtask

  task automatic t_real;
    logic [7:0] v;
    logic [15:0] w;
    mem_read(1'b1, 1'b0, 16'h1234, 16'hBEEF);
    rd(4'h2, v); chk("R4 real single sets bit0", 16'(v), 16'h1);
    rd16(4'h4, w); chk("R12 capture address", w, 16'h1234);
    rd16(4'h6, w); chk("R12 capture data", w, 16'hBEEF);
    wr(4'h2, 8'h00);
    rd(4'h2, v); chk("R8 write 0 keeps flag", 16'(v), 16'h1);
    wr(4'h2, 8'h01);
    rd(4'h2, v); chk("R8 write 1 clears flag", 16'(v), 16'h0);
    mem_read(1'b0, 1'b0, 16'h0001, 16'h0002);
    rd(4'h2, v); chk("R4 clean read sets nothing", 16'(v), 16'h0);
    mem_read(1'b0, 1'b1, 16'h2222, 16'h3333);
    rd(4'h2, v); chk("R4 real double sets bit1", 16'(v), 16'h2);
    wr(4'h2, 8'h03);
  endtask

  task automatic t_both;
    logic [7:0] v;
    logic [15:0] w;
    mem_read(1'b1, 1'b1, 16'hA5A5, 16'h5A5A);
    rd(4'h2, v); chk("R10 both reports set only bit1", 16'(v), 16'h2);
    rd16(4'h4, w); chk("R10 capture holds the read", w, 16'hA5A5);
    wr(4'h2, 8'h03);
  endtask

  task automatic t_force;
    logic [7:0] v;
    logic [15:0] w;
    wr(4'h0, 8'h01);
    @(negedge clk); rd_vld = 1'b0; rd_sgl = 1'b1;
    @(negedge clk); rd_sgl = 1'b0;
    rd(4'h2, v); chk("R9 no strobe no flag", 16'(v), 16'h0);
    mem_read(1'b0, 1'b0, 16'h7777, 16'h8888);
    rd(4'h2, v); chk("R2 forced single sets bit0", 16'(v), 16'h1);
    rd16(4'h4, w); chk("R3 forced read leaves capture", w, 16'hA5A5);
    wr(4'h2, 8'h01);
    mem_read(1'b0, 1'b0, 16'h7778, 16'h8889);
    rd(4'h0, v); chk("R5 force bit persists", 16'(v), 16'h1);
    rd(4'h2, v); chk("R5 force acts again", 16'(v), 16'h1);
    wr(4'h0, 8'h02);
    wr(4'h2, 8'h03);
    mem_read(1'b0, 1'b0, 16'h9999, 16'h1111);
    rd(4'h2, v); chk("R1 forced double sets bit1", 16'(v), 16'h2);
    rd16(4'h6, w); chk("R3 forced double leaves data", w, 16'h5A5A);
    wr(4'h0, 8'h00);
    wr(4'h2, 8'h03);
    mem_read(1'b0, 1'b0, 16'h9999, 16'h1111);
    rd(4'h2, v); chk("R4 force cleared stops flags", 16'(v), 16'h0);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wr(4'h1, 8'hFF);
    rd(4'h1, v); chk("R7 reserved bit reads 0", 16'(v), 16'hDF);
    chk("R6 no flag no irq", 16'(irq), 16'h0);
    wr(4'h1, 8'h01);
    mem_read(1'b0, 1'b1, 16'h0100, 16'h0200);
    chk("R6 disabled flag no irq", 16'(irq), 16'h0);
    wr(4'h1, 8'h02);
    chk("R6 enabled flag irq", 16'(irq), 16'h1);
    wr(4'h2, 8'h02);
    chk("R6 cleared flag drops irq", 16'(irq), 16'h0);
    wr(4'h1, 8'h00);
  endtask

  task automatic t_set_wins;
    logic [7:0] v;
    wr(4'h0, 8'h01);
    @(negedge clk);
    rd_vld = 1'b1; bus_addr = 4'h2; bus_wdata = 8'h01; bus_we = 1'b1;
    @(negedge clk);
    rd_vld = 1'b0; bus_we = 1'b0;
    wr(4'h0, 8'h00);
    rd(4'h2, v); chk("R8 set beats clear", 16'(v), 16'h1);
    wr(4'h2, 8'h03);
  endtask

  task automatic t_hold;
    logic [15:0] w;
    mem_read(1'b1, 1'b0, 16'h0A0A, 16'h0B0B);
    mem_read(1'b1, 1'b0, 16'h0C0C, 16'h0D0D);
    rd16(4'h4, w); chk("R11 first capture kept", w, 16'h0A0A);
    mem_read(1'b0, 1'b1, 16'h0E0E, 16'h0F0F);
    rd16(4'h6, w); chk("R11 other class does not overwrite", w, 16'h0B0B);
    wr(4'h2, 8'h01);
    mem_read(1'b1, 1'b0, 16'h1A1A, 16'h1B1B);
    rd16(4'h4, w); chk("R11 reload after clear", w, 16'h1A1A);
    wr(4'h2, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_real();
    t_both();
    t_force();
    t_irq();
    t_set_wins();
    t_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule